// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the byte-wide host interface of a three-channel interval timer. A host reaches it through a 2-bit address, separate read and write strobes and 8-bit data buses. Addresses 0, 1 and 2 select the count register of channel 0, 1 and 2. Address 3 is the control register. The counting engines sit outside the block. Each engine gives this block its live 16-bit count and its OUT level. In return it receives its programmed mode and BCD flag, and a one-cycle load strobe with the assembled 16-bit reload value.

For every channel the block keeps the access mode and the write and read byte sequencing. It also holds a one-shot snapshot of the count and a one-shot status byte. Control words program a channel or freeze its count. A readback command can freeze the count, the status or both for any set of channels in a single write. On a channel read, a pending status comes out first, then a pending count snapshot, and only then the live count.

Read data is registered. It appears on the clock edge that samples the read strobe and holds until the next read. A load strobe is raised on the clock edge that samples the completing data write. Only one of the read and write strobes is asserted in any cycle.

Top module: `tmr_regif`

## Requirements
- R1: A write to address 3 with bits 7:6 below 3 and a nonzero bits 5:4 programs the channel that bits 7:6 name. From the next cycle the channel's access mode is bits 5:4 (1 low byte only, 2 high byte only, 3 low byte then high byte), its mode is bits 3:1 on `cfg_mode` and its BCD flag is bit 0 on `cfg_bcd`. The write also restarts that channel's write and read byte sequencing at the low byte.
- R2: In access mode 1, a data write raises that channel's `load_stb` bit for exactly one cycle with `load_val` = {8'h00, byte}. No other channel's bit is raised.
- R3: In access mode 2, a data write loads `load_val` = {byte, 8'h00}.
- R4: In access mode 3, the first data write is held and produces no load. The second data write loads {second byte, first byte}.
- R5: Without a pending latch, a channel read returns the live count. Access mode 1 returns the low byte and mode 2 returns the high byte. Mode 3 alternates low, high, low, and so on.
- R6: A control word whose bits 5:4 are 0 snapshots the named channel's live count. Later reads return the snapshot, not the live count, in the channel's access order. In mode 3 the low byte comes first, then the high byte, and after that reads return the live count again.
- R7: A count latch request for a channel whose snapshot is still unread has no effect. The pending snapshot keeps its value.
- R8: A write to address 3 with bits 7:6 = 3 is a readback command. Bit 1 selects channel 0, bit 2 selects channel 1 and bit 3 selects channel 2. Bit 5 = 0 latches the count of each selected channel and bit 4 = 0 latches its status. Channels that are not selected are unaffected.
- R9: The latched status byte holds OUT in bit 7, 0 in bit 6, the access mode in bits 5:4, the mode in bits 3:1 and BCD in bit 0. A read returns it ahead of any pending count and clears it. A status latch request while the status is still unread has no effect.
- R10: In access mode 1 or 2, a single read releases the count snapshot.
- R11: After reset every channel is in access mode 3 with mode 0 and BCD 0. No latch is pending, `load_stb` is 0 and `bus_rdata` is 0x00. A read at address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0..2 channel count, 3 control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| live_count | input | 48 | Live count of each channel, channel 0 in bits 15:0 |
| chan_out | input | 3 | OUT level of each channel |
| cfg_mode | output | 9 | Programmed mode of each channel, 3 bits per channel |
| cfg_bcd | output | 3 | Programmed BCD flag of each channel |
| load_stb | output | 3 | One-cycle reload strobe per channel |
| load_val | output | 16 | Reload value for the strobed channel |

## Verification
Every access mode is exercised with both writes and live reads, so a swapped byte lane or a missing alternation shows up as a wrong byte. Between a latch and the reads that follow it, the bench changes the live count, which separates snapshot data from live data. A second latch request while a snapshot is pending checks that the first snapshot survives. Readback commands are sent with count and status together, count only and status only, on selected and unselected channels. These catch a wrong select-bit mapping, a wrong priority and a status that is overwritten while still pending. A word write abandoned halfway by reprogramming checks that the byte sequencing restarts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 16;
  localparam int MODE_W  = 3;
  localparam int ACC_W   = 2;

  localparam logic [ACC_W-1:0] ACC_LATCH = 2'd0;
  localparam logic [ACC_W-1:0] ACC_LO    = 2'd1;
  localparam logic [ACC_W-1:0] ACC_HI    = 2'd2;
  localparam logic [ACC_W-1:0] ACC_WORD  = 2'd3;

  typedef struct packed {
    logic              out;
    logic              rsvd;
    logic [ACC_W-1:0]  acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
  } stat_t;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NCH-1:0]    prog,
  output logic [NCH-1:0]    cnt_req,
  output logic [NCH-1:0]    st_req,
  output logic [NCH-1:0]    data_wr
);
  localparam logic [1:0] CTL_ADDR = 2'd3;
  localparam logic [1:0] RB_SEL   = 2'd3;

  logic       ctl_wr;
  logic [1:0] sel;
  logic       is_rb;

  assign ctl_wr = wr && (addr == CTL_ADDR);
  assign sel    = wdata[7:6];
  assign is_rb  = (sel == RB_SEL);

  always_comb begin
    prog    = '0;
    cnt_req = '0;
    st_req  = '0;
    data_wr = '0;
    for (int i = 0; i < NCH; i++) begin
      if (wr && addr != CTL_ADDR && int'(addr) == i)
        data_wr[i] = 1'b1;
      if (ctl_wr && is_rb && wdata[1+i]) begin
        cnt_req[i] = !wdata[5];
        st_req[i]  = !wdata[4];
      end
      if (ctl_wr && !is_rb && int'(sel) == i) begin
        if (wdata[5:4] == ACC_LATCH) cnt_req[i] = 1'b1;
        else                         prog[i]    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog,
  input  logic              cnt_req,
  input  logic              st_req,
  input  logic              data_wr,
  input  logic              rd_stb,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic [CNT_W-1:0]  live,
  input  logic              out_i,
  output logic [MODE_W-1:0] cfg_mode,
  output logic              cfg_bcd,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              ld_stb,
  output logic [CNT_W-1:0]  ld_val
);
  logic [ACC_W-1:0]  acc_q, acc_n;
  logic [MODE_W-1:0] mode_q, mode_n;
  logic              bcd_q, bcd_n;
  logic              wr_hi_q, wr_hi_n;
  logic [BYTE_W-1:0] hold_q, hold_n;
  logic              rd_hi_q, rd_hi_n;
  logic              cl_vld_q, cl_vld_n;
  logic              cl_hi_q, cl_hi_n;
  logic [ACC_W-1:0]  cl_acc_q, cl_acc_n;
  logic [CNT_W-1:0]  cl_val_q, cl_val_n;
  logic              st_vld_q, st_vld_n;
  stat_t             st_val_q, st_val_n;
  logic              ld_stb_q, ld_stb_n;
  logic [CNT_W-1:0]  ld_val_q, ld_val_n;

  always_comb begin
    acc_n    = acc_q;
    mode_n   = mode_q;
    bcd_n    = bcd_q;
    wr_hi_n  = wr_hi_q;
    hold_n   = hold_q;
    rd_hi_n  = rd_hi_q;
    cl_vld_n = cl_vld_q;
    cl_hi_n  = cl_hi_q;
    cl_acc_n = cl_acc_q;
    cl_val_n = cl_val_q;
    st_vld_n = st_vld_q;
    st_val_n = st_val_q;
    ld_stb_n = 1'b0;
    ld_val_n = ld_val_q;

    if (prog) begin
      acc_n   = wbyte[5:4];
      mode_n  = wbyte[3:1];
      bcd_n   = wbyte[0];
      wr_hi_n = 1'b0;
      rd_hi_n = 1'b0;
    end

    if (cnt_req && !cl_vld_q) begin
      cl_vld_n = 1'b1;
      cl_hi_n  = 1'b0;
      cl_acc_n = acc_q;
      cl_val_n = live;
    end

    if (st_req && !st_vld_q) begin
      st_vld_n = 1'b1;
      st_val_n = '{out: out_i, rsvd: 1'b0, acc: acc_q, mode: mode_q, bcd: bcd_q};
    end

    if (data_wr) begin
      unique case (acc_q)
        ACC_LO: begin
          ld_stb_n = 1'b1;
          ld_val_n = {8'h00, wbyte};
        end
        ACC_HI: begin
          ld_stb_n = 1'b1;
          ld_val_n = {wbyte, 8'h00};
        end
        ACC_WORD: begin
          if (!wr_hi_q) begin
            hold_n  = wbyte;
            wr_hi_n = 1'b1;
          end else begin
            ld_stb_n = 1'b1;
            ld_val_n = {wbyte, hold_q};
            wr_hi_n  = 1'b0;
          end
        end
        default: ;
      endcase
    end

    if (rd_stb) begin
      if (st_vld_q) begin
        st_vld_n = 1'b0;
      end else if (cl_vld_q) begin
        if (cl_acc_q == ACC_WORD && !cl_hi_q) cl_hi_n  = 1'b1;
        else                                  cl_vld_n = 1'b0;
      end else if (acc_q == ACC_WORD) begin
        rd_hi_n = !rd_hi_q;
      end
    end
  end

  always_comb begin
    if (st_vld_q) begin
      rd_byte = st_val_q;
    end else if (cl_vld_q) begin
      if (cl_acc_q == ACC_HI || (cl_acc_q == ACC_WORD && cl_hi_q)) rd_byte = cl_val_q[15:8];
      else                                                          rd_byte = cl_val_q[7:0];
    end else begin
      if (acc_q == ACC_HI || (acc_q == ACC_WORD && rd_hi_q)) rd_byte = live[15:8];
      else                                                    rd_byte = live[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= ACC_WORD;
      mode_q   <= '0;
      bcd_q    <= 1'b0;
      wr_hi_q  <= 1'b0;
      hold_q   <= '0;
      rd_hi_q  <= 1'b0;
      cl_vld_q <= 1'b0;
      cl_hi_q  <= 1'b0;
      cl_acc_q <= ACC_WORD;
      cl_val_q <= '0;
      st_vld_q <= 1'b0;
      st_val_q <= '0;
      ld_stb_q <= 1'b0;
      ld_val_q <= '0;
    end else begin
      acc_q    <= acc_n;
      mode_q   <= mode_n;
      bcd_q    <= bcd_n;
      wr_hi_q  <= wr_hi_n;
      hold_q   <= hold_n;
      rd_hi_q  <= rd_hi_n;
      cl_vld_q <= cl_vld_n;
      cl_hi_q  <= cl_hi_n;
      cl_acc_q <= cl_acc_n;
      cl_val_q <= cl_val_n;
      st_vld_q <= st_vld_n;
      st_val_q <= st_val_n;
      ld_stb_q <= ld_stb_n;
      ld_val_q <= ld_val_n;
    end
  end

  assign cfg_mode = mode_q;
  assign cfg_bcd  = bcd_q;
  assign ld_stb   = ld_stb_q;
  assign ld_val   = ld_val_q;

  // R1: programming takes the access field from the written byte
  a_r1_prog_applies: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> acc_q == $past(wbyte[5:4]));

  // R4: the first byte of a word write never loads
  a_r4_first_byte_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && acc_q == ACC_WORD && !wr_hi_q) |=> !ld_stb_q);

  // R7: a pending snapshot keeps its value until read
  a_r7_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_vld_q && !rd_stb) |=> (cl_vld_q && $stable(cl_val_q)));

  // R9: reading a pending status clears it
  a_r9_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (st_vld_q && rd_stb && !st_req) |=> !st_vld_q);
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  input  logic [NCH*CNT_W-1:0]  live_count,
  input  logic [NCH-1:0]        chan_out,
  output logic [NCH*MODE_W-1:0] cfg_mode,
  output logic [NCH-1:0]        cfg_bcd,
  output logic [NCH-1:0]        load_stb,
  output logic [CNT_W-1:0]      load_val
);
  logic [NCH-1:0]        prog, cnt_req, st_req, data_wr, rd_sel;
  logic [BYTE_W-1:0]     ch_byte [NCH];
  logic [CNT_W-1:0]      ch_ld   [NCH];
  logic [BYTE_W-1:0]     rdata_q, rdata_n;

  tmr_cmd_decode #(.NCH(NCH)) u_dec (
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .prog(prog), .cnt_req(cnt_req), .st_req(st_req), .data_wr(data_wr)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign rd_sel[g] = bus_rd && (int'(bus_addr) == g);
    tmr_chan_regs u_ch (
      .clk(clk), .rst_n(rst_n),
      .prog(prog[g]), .cnt_req(cnt_req[g]), .st_req(st_req[g]),
      .data_wr(data_wr[g]), .rd_stb(rd_sel[g]), .wbyte(bus_wdata),
      .live(live_count[g*CNT_W +: CNT_W]), .out_i(chan_out[g]),
      .cfg_mode(cfg_mode[g*MODE_W +: MODE_W]), .cfg_bcd(cfg_bcd[g]),
      .rd_byte(ch_byte[g]), .ld_stb(load_stb[g]), .ld_val(ch_ld[g])
    );
  end

  always_comb begin
    rdata_n = rdata_q;
    if (bus_rd) begin
      rdata_n = '0;
      for (int i = 0; i < NCH; i++)
        if (int'(bus_addr) == i) rdata_n = ch_byte[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_n;
  end

  always_comb begin
    load_val = '0;
    for (int i = 0; i < NCH; i++)
      if (load_stb[i]) load_val = ch_ld[i];
  end

  assign bus_rdata = rdata_q;

  // R2: at most one channel is reloaded in any cycle
  a_r2_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_stb));

  // R11: the control address reads back as zero
  a_r11_ctl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd3) |=> bus_rdata == 8'h00);
endmodule

// File: tb/sim_tmr_regif.sv
`timescale 1ns/1ps
module sim_tmr_regif;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [47:0] live_count;
  logic [2:0]  chan_out;
  logic [8:0]  cfg_mode;
  logic [2:0]  cfg_bcd, load_stb;
  logic [15:0] load_val;

  always #2 clk = ~clk;

  tmr_regif u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .live_count(live_count),
    .chan_out(chan_out), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
    .load_stb(load_stb), .load_val(load_val)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit rd_seen = 0;
  logic [7:0]  rq_v[$];
  string       rq_t[$];
  logic [2:0]  lq_s[$];
  logic [15:0] lq_v[$];
  string       lq_t[$];

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rst_n && rd_seen) begin
      if (rq_v.size() == 0) check(32'(bus_rdata), 32'hFFFF, "R5 unexpected read");
      else begin
        logic [7:0] v;
        string t;
        v = rq_v.pop_front();
        t = rq_t.pop_front();
        check(32'(bus_rdata), 32'(v), t);
      end
    end
    if (rst_n && load_stb != 3'b000) begin
      if (lq_v.size() == 0) check({13'h0, load_stb, load_val}, 32'h0, "R4 unexpected load");
      else begin
        logic [2:0]  s;
        logic [15:0] v;
        string t;
        s = lq_s.pop_front();
        v = lq_v.pop_front();
        t = lq_t.pop_front();
        check({13'h0, load_stb, load_val}, {13'h0, s, v}, t);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    rq_v.push_back(exp);
    rq_t.push_back(tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic exp_load(input logic [2:0] s, input logic [15:0] v, input string tag);
    lq_s.push_back(s);
    lq_v.push_back(v);
    lq_t.push_back(tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    live_count = {16'h9ABC, 16'h5678, 16'h1234};
    chan_out = 3'b000;
    repeat (3) @(negedge clk);
    check(32'(load_stb), 0, "R11 reset load_stb");
    check(32'(bus_rdata), 0, "R11 reset rdata");
    check(32'(cfg_mode), 0, "R11 reset mode");
    check(32'(cfg_bcd), 0, "R11 reset bcd");
    rst_n = 1'b1;

    // R11 / R5: default word access, live low then high
    rd(0, 8'h34, "R11 default word low");
    rd(0, 8'h12, "R5 word live high");

    // R1 / R2: ch0 low-only, mode 2, bcd 1
    wr(3, 8'h15);
    check(32'(cfg_mode[2:0]), 2, "R1 ch0 mode");
    check(32'(cfg_bcd[0]), 1, "R1 ch0 bcd");
    exp_load(3'b001, 16'h00AB, "R2 low-only load");
    wr(0, 8'hAB);
    rd(0, 8'h34, "R5 low-only read");
    rd(0, 8'h34, "R5 low-only repeat");

    // R3: ch1 high-only, mode 3
    wr(3, 8'h66);
    check(32'(cfg_mode[5:3]), 3, "R1 ch1 mode");
    exp_load(3'b010, 16'hCD00, "R3 high-only load");
    wr(1, 8'hCD);
    rd(1, 8'h56, "R5 high-only read");

    // R4 / R5: ch2 word, mode 4
    wr(3, 8'hB8);
    check(32'(cfg_mode[8:6]), 4, "R1 ch2 mode");
    wr(2, 8'h34);
    exp_load(3'b100, 16'h1234, "R4 word load");
    wr(2, 8'h12);
    rd(2, 8'hBC, "R5 word alt low");
    rd(2, 8'h9A, "R5 word alt high");
    rd(2, 8'hBC, "R5 word alt low again");

    // R1: reprogram mid-word restarts sequencing
    wr(2, 8'h77);
    wr(3, 8'hB8);
    exp_load(3'b100, 16'h2211, "R1 sequence restart");
    wr(2, 8'h11);
    wr(2, 8'h22);

    // R6 / R7: count latch on ch2
    live_count[47:32] = 16'h5A3C;
    wr(3, 8'h80);
    live_count[47:32] = 16'h9999;
    rd(2, 8'h3C, "R6 latched low");
    wr(3, 8'h80);
    rd(2, 8'h5A, "R7 latched high kept");
    rd(2, 8'h99, "R6 released to live");

    // R8 / R9 / R10: readback count+status on ch0 and ch2
    chan_out = 3'b101;
    live_count[15:0]  = 16'h1111;
    live_count[47:32] = 16'h2222;
    wr(3, 8'hCA);
    live_count[15:0]  = 16'h3344;
    live_count[47:32] = 16'h5566;
    rd(0, 8'h95, "R9 ch0 status first");
    rd(0, 8'h11, "R10 ch0 latched low");
    rd(0, 8'h44, "R10 ch0 released");
    rd(2, 8'hB8, "R9 ch2 status");
    rd(2, 8'h22, "R8 ch2 latched low");
    rd(2, 8'h22, "R8 ch2 latched high");
    rd(2, 8'h55, "R8 ch2 live after");
    rd(1, 8'h56, "R8 ch1 unselected");

    // R9: status-only readback on ch1, second request ignored
    wr(3, 8'hE4);
    chan_out = 3'b111;
    wr(3, 8'hE4);
    rd(1, 8'h26, "R9 status kept");
    rd(1, 8'h56, "R8 status-only no count");

    // R8: count-only readback on ch0
    live_count[15:0] = 16'h7788;
    wr(3, 8'hD2);
    live_count[15:0] = 16'h0000;
    rd(0, 8'h88, "R8 count-only latched");
    rd(0, 8'h00, "R10 count-only released");

    // R11: control address reads zero
    rd(3, 8'h00, "R11 ctl read");

    repeat (4) @(negedge clk);
    check(32'(rq_v.size()), 0, "R5 read queue drained");
    check(32'(lq_v.size()), 0, "R4 load queue drained");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule